// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt Vector

This block is a per-processor countdown timer seen by software as four 32-bit registers in a 4 KiB window. The window starts at a base address parameter, 0xFEE00000 by default. A control entry holds the interrupt vector, a mask bit and a one-shot/periodic select. A reload register holds the start value. A read-only register shows the live count. A prescaler register picks how many bus clocks make one count step. Writing the reload register copies the value into the live count and starts the countdown, or restarts it if one is already running. When the count reaches zero the block raises a one-cycle interrupt request, and the control entry's vector is shown beside it.

The count is run by a three-state machine. IDLE means never started or stopped by a zero load. RUN means counting down. EXPIRED means a one-shot countdown has ended and the count is held at zero. The transitions are:

- LOAD_GO (IDLE, RUN or EXPIRED to RUN): a write of a non-zero value to the reload register.
- LOAD_STOP (any state to IDLE): a write of zero to the reload register.
- WRAP (RUN to RUN): the count hits zero in periodic mode and is reloaded.
- FINISH (RUN to EXPIRED): the count hits zero in one-shot mode.

A masked timer still counts and follows every transition, but it raises no request.

Top module: `apic_ctdn_timer`

## Requirements
- R1: After reset, the control entry reads 0x00010000 (mask set, one-shot, vector 0). The reload, live count and prescaler registers read 0, and the request output is low.
- R2: With division ratio N, after a non-zero reload write of V, a read of the live count j clocks after the write edge returns V - floor(j/N).
- R3: In one-shot mode (control bit 17 = 0), exactly one request pulse appears in the cycle after the edge V*N clocks past the reload write. After that the live count reads 0 and no further request appears.
- R4: In periodic mode (control bit 17 = 1), a request pulse appears every V*N clocks after the reload write, and the count restarts from the reload value each time.
- R5: A reload write during a running countdown discards the old count, and the next request comes V*N clocks after the new write.
- R6: Writing zero to the reload register stops the count. The live count reads 0 and no request is raised.
- R7: The prescaler code is formed from register bits {3,1,0}. Codes 0 to 6 divide by 2, 4, 8, 16, 32, 64 and 128, and code 7 divides by 1. The register reads back only those three bits.
- R8: While control bit 16 (mask) is 1, the countdown runs to zero but no request is raised.
- R9: While a request is high, the vector output equals control bits 7..0.
- R10: Writes to the live count register (offset 0x390) have no effect. The control entry reads back only bits 7..0, 16 and 17. The offsets are: control 0x320, reload 0x380, live count 0x390, prescaler 0x3E0.
- R11: Accesses whose address bits 31..12 differ from the base are ignored, and such reads return 0. Reads return data one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 32 | Full byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector from the control entry |

## Verification
One-shot expiry is swept over all eight prescaler codes with reload values 1 to 3. This separates a wrong ratio from an off-by-one in the count or in the prescaler phase, and it checks that the vector follows the control entry. Periodic runs with two ratios show whether the reload keeps the period exact across several wraps. Mid-count reads at points either side of a prescaler boundary show whether steps land on the right edge. Restart, zero-load, masked and out-of-window cases each separate "ignored" from "acted on" by watching the request line and reading the registers back.

// File: rtl/apic_tmr_pkg.sv
package apic_tmr_pkg;

    typedef enum logic [1:0] {
        TS_IDLE    = 2'd0,
        TS_RUN     = 2'd1,
        TS_EXPIRED = 2'd2
    } tmr_state_e;

    localparam logic [11:0] OFS_CTRL   = 12'h320;
    localparam logic [11:0] OFS_RELOAD = 12'h380;
    localparam logic [11:0] OFS_LIVE   = 12'h390;
    localparam logic [11:0] OFS_PRESC  = 12'h3E0;

    localparam int CTRL_MASK_BIT = 16;
    localparam int CTRL_PER_BIT  = 17;

    // prescaler code to log2 of division ratio; code 7 means divide by 1
    function automatic logic [2:0] presc_shift(input logic [2:0] code);
        return (code == 3'd7) ? 3'd0 : code + 3'd1;
    endfunction

endpackage

// File: rtl/apic_tmr_regs.sv
module apic_tmr_regs
    import apic_tmr_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'hFEE0_0000,
    parameter int          CNT_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [31:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    input  logic [CNT_W-1:0] live_cnt,
    output logic [31:0]      bus_rdata,
    output logic [7:0]       vec,
    output logic             masked,
    output logic             periodic,
    output logic [2:0]       presc_code,
    output logic [CNT_W-1:0] reload_val,
    output logic             load_stb
);

    logic        in_window;
    logic [11:0] ofs;
    logic [31:0] rd_mux;

    assign in_window = (bus_addr[31:12] == BASE_ADDR[31:12]);
    assign ofs       = bus_addr[11:0];
    assign load_stb  = bus_wr && in_window && (ofs == OFS_RELOAD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec        <= '0;
            masked     <= 1'b1;
            periodic   <= 1'b0;
            presc_code <= '0;
            reload_val <= '0;
        end else if (bus_wr && in_window) begin
            unique case (ofs)
                OFS_CTRL: begin
                    vec      <= bus_wdata[7:0];
                    masked   <= bus_wdata[CTRL_MASK_BIT];
                    periodic <= bus_wdata[CTRL_PER_BIT];
                end
                OFS_RELOAD: reload_val <= bus_wdata[CNT_W-1:0];
                OFS_PRESC:  presc_code <= {bus_wdata[3], bus_wdata[1:0]};
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        if (in_window) begin
            unique case (ofs)
                OFS_CTRL:   rd_mux = {14'd0, periodic, masked, 8'd0, vec};
                OFS_RELOAD: rd_mux = 32'(reload_val);
                OFS_LIVE:   rd_mux = 32'(live_cnt);
                OFS_PRESC:  rd_mux = {28'd0, presc_code[2], 1'b0, presc_code[1:0]};
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // the prescaler register keeps only its three code bits
    assert_presc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && in_window && ofs == OFS_PRESC) |=> $stable(presc_code));

    // writes outside the window leave the reload value alone
    assert_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_window) |=> $stable(reload_val));

endmodule

// File: rtl/apic_tmr_prescale.sv
module apic_tmr_prescale #(
    parameter int MAX_SHIFT = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] shift,
    output logic       tick
);

    localparam int PW = MAX_SHIFT;

    logic [PW-1:0] phase;
    logic [PW-1:0] wrap_mask;

    assign wrap_mask = PW'((1 << shift) - 1);
    assign tick      = ((phase & wrap_mask) == wrap_mask);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    // divide-by-one makes every clock a count step
    assert_div1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift == 3'd0) |-> tick);

    // with a ratio above one, no step happens in the first cycle after restart
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && shift != 3'd0) |=> (!tick || $past(shift) != shift));

endmodule

// File: rtl/apic_tmr_count.sv
module apic_tmr_count
    import apic_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             tick,
    output logic [CNT_W-1:0] live_cnt,
    output logic             expire
);

    tmr_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             at_end;

    assign at_end = (state == TS_RUN) && tick && (live_cnt == CNT_W'(1)) && !load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TS_IDLE;
            live_cnt <= '0;
        end else begin
            state    <= state_nx;
            live_cnt <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = live_cnt;
        expire   = 1'b0;
        if (load) begin
            cnt_nx   = load_val;
            state_nx = (load_val == '0) ? TS_IDLE : TS_RUN;
        end else begin
            unique case (state)
                TS_IDLE: ;
                TS_RUN: begin
                    if (at_end) begin
                        expire = 1'b1;
                        if (periodic) begin
                            cnt_nx = reload_val;
                        end else begin
                            cnt_nx   = '0;
                            state_nx = TS_EXPIRED;
                        end
                    end else if (tick) begin
                        cnt_nx = live_cnt - 1'b1;
                    end
                end
                TS_EXPIRED: ;
                default: state_nx = TS_IDLE;
            endcase
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_RUN && !load && !tick) |=> $stable(live_cnt));

    assert_expired_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_EXPIRED && !load) |=> (live_cnt == '0 && state == TS_EXPIRED));

    assert_zero_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (state == TS_IDLE && live_cnt == '0));

    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> (state == TS_RUN && live_cnt == $past(load_val)));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> (state == TS_RUN));

endmodule

// File: rtl/apic_ctdn_timer.sv
module apic_ctdn_timer
    import apic_tmr_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'hFEE0_0000,
    parameter int          CNT_W     = 32,
    parameter int          MAX_SHIFT = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_req,
    output logic [7:0]  irq_vector
);

    logic [CNT_W-1:0] live_cnt, reload_val;
    logic [7:0]       vec;
    logic             masked, periodic, load_stb, tick, expire;
    logic [2:0]       presc_code;

    apic_tmr_regs #(.BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .live_cnt(live_cnt),
        .bus_rdata(bus_rdata), .vec(vec), .masked(masked), .periodic(periodic),
        .presc_code(presc_code), .reload_val(reload_val), .load_stb(load_stb)
    );

    apic_tmr_prescale #(.MAX_SHIFT(MAX_SHIFT)) presc_i (
        .clk(clk), .rst_n(rst_n), .restart(load_stb),
        .shift(presc_shift(presc_code)), .tick(tick)
    );

    apic_tmr_count #(.CNT_W(CNT_W)) count_i (
        .clk(clk), .rst_n(rst_n), .load(load_stb),
        .load_val(bus_wdata[CNT_W-1:0]), .reload_val(reload_val),
        .periodic(periodic), .tick(tick), .live_cnt(live_cnt), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq_req <= 1'b0;
        else        irq_req <= expire && !masked;
    end

    assign irq_vector = vec;

    assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !$past(masked));

    assert_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(expire));

endmodule

// File: tb/apic_ctdn_timer_tb.sv
module apic_ctdn_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'hFEE0_0000;
    localparam logic [31:0] A_CTRL = BASE | 32'h320;
    localparam logic [31:0] A_RLD  = BASE | 32'h380;
    localparam logic [31:0] A_LIVE = BASE | 32'h390;
    localparam logic [31:0] A_PRE  = BASE | 32'h3E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;

    int tests = 0, fails = 0;
    int hits[4];
    logic [7:0] hvec[4];
    int nh;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    apic_ctdn_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic watch(input int limit);
        nh = 0;
        for (int c = 1; c <= limit; c++) begin
            @(posedge clk); @(negedge clk);
            if (irq_req) begin
                if (nh < 4) begin hits[nh] = c; hvec[nh] = irq_vector; end
                nh++;
            end
        end
    endtask

    function automatic int ratio(input int code);
        return (code == 7) ? 1 : (2 << code);
    endfunction

    function automatic logic [31:0] presc_word(input int code);
        return {28'd0, code[2], 1'b0, code[1:0]};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; tests++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check(irq_req == 1'b0, "R1 irq", {31'd0, irq_req}, 32'd0);
        rd(A_CTRL, rv); check(rv == 32'h0001_0000, "R1 ctrl", rv, 32'h0001_0000);
        rd(A_RLD, rv);  check(rv == 32'd0, "R1 reload", rv, 32'd0);
        rd(A_LIVE, rv); check(rv == 32'd0, "R1 live", rv, 32'd0);
        rd(A_PRE, rv);  check(rv == 32'd0, "R1 presc", rv, 32'd0);

        // R10 readback masks, R7 prescaler readback
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, rv); check(rv == 32'h0003_00FF, "R10 ctrl bits", rv, 32'h0003_00FF);
        wr(A_PRE, 32'hFFFF_FFFF);
        rd(A_PRE, rv);  check(rv == 32'h0000_000B, "R7 presc bits", rv, 32'h0000_000B);

        // R3 R7 R9 one-shot sweep over all codes
        for (int code = 0; code < 8; code++) begin
            for (int v = 1; v <= 3; v++) begin
                int n;
                n = ratio(code);
                wr(A_PRE, presc_word(code));
                wr(A_CTRL, 32'h40 + code);
                wr(A_RLD, v);
                watch(v * n + 2 * n + 4);
                check(nh == 1, "R3 one pulse", nh, 1);
                check(hits[0] == v * n, "R7 expiry time", hits[0], v * n);
                check(hvec[0] == 8'(32'h40 + code), "R9 vector", {24'd0, hvec[0]}, 32'h40 + code);
                rd(A_LIVE, rv); check(rv == 32'd0, "R3 held zero", rv, 0);
            end
        end

        // R2 mid-count reads, ratio 4
        foreach (hits[k]) hits[k] = 0;
        begin
            int waits[4] = '{0, 3, 4, 9};
            for (int k = 0; k < 4; k++) begin
                wr(A_PRE, presc_word(1));
                wr(A_RLD, 10);
                repeat (waits[k]) @(negedge clk);
                rd(A_LIVE, rv);
                check(rv == 10 - waits[k] / 4, "R2 live count", rv, 10 - waits[k] / 4);
            end
        end
        wr(A_RLD, 0);

        // R4 periodic, ratios 1 and 2
        for (int k = 0; k < 2; k++) begin
            int code, v, n;
            code = (k == 0) ? 7 : 0;
            v = (k == 0) ? 5 : 3;
            n = ratio(code);
            wr(A_PRE, presc_word(code));
            wr(A_CTRL, 32'h0002_0021);
            wr(A_RLD, v);
            watch(3 * v * n + 1);
            check(nh == 3, "R4 pulse count", nh, 3);
            for (int p = 0; p < 3; p++)
                check(hits[p] == (p + 1) * v * n, "R4 period", hits[p], (p + 1) * v * n);
            wr(A_RLD, 0);
        end

        // R5 restart while running
        wr(A_PRE, presc_word(7));
        wr(A_CTRL, 32'h22);
        wr(A_RLD, 100);
        repeat (10) @(negedge clk);
        wr(A_RLD, 5);
        watch(120);
        check(nh == 1, "R5 pulses", nh, 1);
        check(hits[0] == 5, "R5 restart time", hits[0], 5);

        // R6 zero load stops
        wr(A_RLD, 4);
        @(negedge clk);
        wr(A_RLD, 0);
        watch(10);
        check(nh == 0, "R6 no irq", nh, 0);
        rd(A_LIVE, rv); check(rv == 32'd0, "R6 live zero", rv, 0);

        // R8 masked countdown
        wr(A_CTRL, 32'h0001_0023);
        wr(A_RLD, 3);
        rd(A_LIVE, rv); check(rv == 32'd3, "R8 counting", rv, 3);
        watch(8);
        check(nh == 0, "R8 masked", nh, 0);
        rd(A_LIVE, rv); check(rv == 32'd0, "R8 reached zero", rv, 0);

        // R10 live count is read-only
        wr(A_CTRL, 32'h24);
        wr(A_LIVE, 32'h1234);
        rd(A_LIVE, rv); check(rv == 32'd0, "R10 live ro", rv, 0);
        watch(4);
        check(nh == 0, "R10 no start", nh, 0);

        // R11 out-of-window accesses
        wr(A_RLD, 9);
        wr(A_RLD + 32'h1000, 7);
        rd(A_RLD, rv); check(rv == 32'd9, "R11 write ignored", rv, 9);
        rd(A_RLD + 32'h1000, rv); check(rv == 32'd0, "R11 read zero", rv, 0);
        wr(A_RLD, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule